// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block derives the timing of a serial port from a selected source clock. A bus-writable configuration word holds an integer divisor and a three-bit fraction in eighths. A divider state machine turns these into an oversampling clock level and a one-cycle oversampling tick. A second stage divides those ticks by a factor that depends on the port mode, which gives a one-cycle bit tick. An input that enables write protection freezes the configuration word.

The divider state machine has three states. `ST_IDLE` is entered when the divisor is zero. The clock high phase is `ST_HIGH`, and the clock low phase is `ST_LOW`. Its transitions are as follows:
- **start:** `ST_IDLE` moves to `ST_HIGH` once a nonzero divisor is present.
- **half:** `ST_HIGH` moves to `ST_LOW` when the high count runs out and a low phase exists.
- **reload:** at the end of a period, `ST_HIGH` or `ST_LOW` moves to `ST_HIGH` and loads the current divisor and fraction.
- **stop:** at the end of a period, `ST_HIGH` or `ST_LOW` moves to `ST_IDLE` when the divisor is now zero.

A three-bit accumulator spreads the fraction over the periods. A period whose accumulator sum carries out runs one source clock longer, and that extra cycle lands in its high phase.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset, `cfg_rdata` reads 0 and neither `os_tick` nor `bit_tick` pulses.
- R2: A write stores `cfg_wdata[15:0]` as the divisor (CD) and `cfg_wdata[18:16]` as the fraction (FP). Read-back returns CD in bits 15:0 and FP in bits 18:16, and every other bit reads as 0.
- R3: A write issued while `wprot_en` is 1 leaves the stored configuration unchanged.
- R4: With CD = 0 the divider sits in `ST_IDLE`, neither tick pulses, and the bit-stage count is cleared.
- R5: With FP = 0 and CD ≥ 2, `os_tick` pulses every CD cycles, and `os_clk` is high for ceil(CD/2) cycles of each period.
- R6: With FP > 0, the accumulator starts at 0 when the divider leaves `ST_IDLE` and adds FP once per period. A period whose sum carries past 7 lasts CD+1 cycles, and its high phase lasts ceil(CD/2)+1 cycles. Exactly FP of every 8 periods are extended.
- R7: With `ser_mode` = 0 (asynchronous) and `over8` = 0, `bit_tick` pulses on every 16th `os_tick`, and only together with an `os_tick`.
- R8: With `ser_mode` = 0 and `over8` = 1, `bit_tick` pulses on every 8th `os_tick`.
- R9: With `ser_mode` = 1 (synchronous) or 2 (SPI), `bit_tick` equals `os_tick`.
- R10: With `ser_mode` = 3 (smart card), `bit_tick` pulses on every `card_ratio`-th `os_tick`. A ratio of 0 behaves as 1.
- R11: When CD changes from 0 to a nonzero value, the first `os_tick` appears in the CD-th cycle after the write is clocked in, and no earlier tick occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Selected source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read-back |
| wprot_en | input | 1 | When 1, configuration writes are dropped |
| ser_mode | input | 2 | 0 async, 1 sync, 2 SPI, 3 smart card |
| over8 | input | 1 | Async oversampling select: 0 is 16x, 1 is 8x |
| card_ratio | input | 11 | Smart-card division ratio |
| os_tick | output | 1 | One-cycle pulse ending each oversampling period |
| os_clk | output | 1 | Oversampling clock level (high phase first) |
| bit_tick | output | 1 | One-cycle pulse ending each bit period |

## Verification
A wrong down-counter or a wrong low-phase length changes the spacing of `os_tick` within one period. A wrong split between the high and low phases changes how many cycles `os_clk` stays high inside that period. A faulty accumulator changes which periods are stretched, or how many. This shows up within one cycle of eight periods, because the bench checks each period against the exact sequence that an accumulator cleared on start produces. A wrong factor or a wrong count in the bit stage moves `bit_tick` off its expected spacing by the second bit period after a mode change.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } div_state_e;

    typedef enum logic [1:0] {
        MD_ASYNC = 2'd0,
        MD_SYNC  = 2'd1,
        MD_SPI   = 2'd2,
        MD_CARD  = 2'd3
    } ser_mode_e;

endpackage

// File: rtl/fbg_cfg_reg.sv
module fbg_cfg_reg #(
    parameter int DATA_W = 32,
    parameter int CD_W   = 16,
    parameter int FP_W   = 3,
    parameter int FP_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              wprot,
    input  logic [DATA_W-1:0] wdata,
    output logic [CD_W-1:0]   cd,
    output logic [FP_W-1:0]   fp,
    output logic [DATA_W-1:0] rdata
);

    logic [CD_W-1:0] cd_q;
    logic [FP_W-1:0] fp_q;
    logic            wr_ok;

    assign wr_ok = we && !wprot;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cd_q <= '0;
            fp_q <= '0;
        end else if (wr_ok) begin
            cd_q <= wdata[CD_W-1:0];
            fp_q <= wdata[FP_LSB +: FP_W];
        end
    end

    always_comb begin
        rdata = '0;
        rdata[CD_W-1:0]      = cd_q;
        rdata[FP_LSB +: FP_W] = fp_q;
    end

    assign cd = cd_q;
    assign fp = fp_q;

endmodule

// File: rtl/fbg_div_core.sv
module fbg_div_core
    import fbg_pkg::*;
#(
    parameter int CD_W = 16,
    parameter int FP_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CD_W-1:0] cd,
    input  logic [FP_W-1:0] fp,
    output logic            os_tick,
    output logic            os_clk,
    output logic            idle
);

    localparam logic [CD_W-1:0] ONE = CD_W'(1);

    div_state_e      state_q, state_d;
    logic [CD_W-1:0] cnt_q, cnt_d;
    logic [CD_W-1:0] lo_q, lo_d;
    logic [FP_W-1:0] acc_q, acc_d;
    logic [FP_W-1:0] acc_base;
    logic [FP_W:0]   acc_sum;
    logic            ext;
    logic [CD_W-1:0] hi_load;
    logic            load;

    // fractional accumulator: restarts from zero when leaving idle
    always_comb begin
        acc_base = (state_q == ST_IDLE) ? '0 : acc_q;
        acc_sum  = {1'b0, acc_base} + {1'b0, fp};
        ext      = acc_sum[FP_W];
        hi_load  = ((cd - ONE) >> 1) + CD_W'(ext);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        lo_d    = lo_q;
        acc_d   = acc_q;
        load    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cd != '0) load = 1'b1;
            end
            ST_HIGH: begin
                if (cnt_q == '0) begin
                    if (lo_q == '0) begin
                        load = 1'b1;
                    end else begin
                        state_d = ST_LOW;
                        cnt_d   = lo_q - ONE;
                    end
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
            ST_LOW: begin
                if (cnt_q == '0) load = 1'b1;
                else             cnt_d = cnt_q - ONE;
            end
            default: state_d = ST_IDLE;
        endcase
        if (load) begin
            if (cd == '0) begin
                state_d = ST_IDLE;
            end else begin
                state_d = ST_HIGH;
                cnt_d   = hi_load;
                lo_d    = cd >> 1;
                acc_d   = acc_sum[FP_W-1:0];
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            lo_q    <= '0;
            acc_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            lo_q    <= lo_d;
            acc_q   <= acc_d;
        end
    end

    // outputs
    always_comb begin
        os_clk  = (state_q == ST_HIGH);
        idle    = (state_q == ST_IDLE);
        os_tick = ((state_q == ST_HIGH) && (cnt_q == '0) && (lo_q == '0)) ||
                  ((state_q == ST_LOW)  && (cnt_q == '0));
    end

endmodule

// File: rtl/fbg_rate_div.sv
module fbg_rate_div
    import fbg_pkg::*;
#(
    parameter int RATIO_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode,
    input  logic               over8,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               os_tick,
    input  logic               idle,
    output logic               bit_tick
);

    localparam int FC_W = (RATIO_W > 5) ? RATIO_W : 5;

    logic [FC_W-1:0] factor;
    logic [FC_W-1:0] lim;
    logic [FC_W-1:0] cnt_q;

    always_comb begin
        unique case (ser_mode_e'(mode))
            MD_ASYNC:        factor = over8 ? FC_W'(8) : FC_W'(16);
            MD_SYNC, MD_SPI: factor = FC_W'(1);
            MD_CARD:         factor = (ratio == '0) ? FC_W'(1) : FC_W'(ratio);
            default:         factor = FC_W'(1);
        endcase
        lim      = factor - FC_W'(1);
        bit_tick = os_tick && (cnt_q >= lim);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || idle) begin
            cnt_q <= '0;
        end else if (os_tick) begin
            cnt_q <= bit_tick ? '0 : cnt_q + FC_W'(1);
        end
    end

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
    parameter int DATA_W  = 32,
    parameter int CD_W    = 16,
    parameter int FP_W    = 3,
    parameter int FP_LSB  = 16,
    parameter int RATIO_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [DATA_W-1:0]  cfg_wdata,
    output logic [DATA_W-1:0]  cfg_rdata,
    input  logic               wprot_en,
    input  logic [1:0]         ser_mode,
    input  logic               over8,
    input  logic [RATIO_W-1:0] card_ratio,
    output logic               os_tick,
    output logic               os_clk,
    output logic               bit_tick
);

    logic [CD_W-1:0] cd;
    logic [FP_W-1:0] fp;
    logic            core_idle;

    fbg_cfg_reg #(
        .DATA_W(DATA_W), .CD_W(CD_W), .FP_W(FP_W), .FP_LSB(FP_LSB)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wprot(wprot_en),
        .wdata(cfg_wdata), .cd(cd), .fp(fp), .rdata(cfg_rdata)
    );

    fbg_div_core #(
        .CD_W(CD_W), .FP_W(FP_W)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .cd(cd), .fp(fp),
        .os_tick(os_tick), .os_clk(os_clk), .idle(core_idle)
    );

    fbg_rate_div #(
        .RATIO_W(RATIO_W)
    ) u_rate (
        .clk(clk), .rst_n(rst_n), .mode(ser_mode), .over8(over8),
        .ratio(card_ratio), .os_tick(os_tick), .idle(core_idle),
        .bit_tick(bit_tick)
    );

endmodule

// File: rtl/fbg_chk.sv
module fbg_chk #(
    parameter int DATA_W = 32,
    parameter int FP_W   = 3,
    parameter int FP_LSB = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              wprot_en,
    input logic [DATA_W-1:0] cfg_rdata,
    input logic [1:0]        ser_mode,
    input logic              os_tick,
    input logic              bit_tick,
    input logic              core_idle
);

    // R3
    wprot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && wprot_en) |=> $stable(cfg_rdata));

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[DATA_W-1:FP_LSB+FP_W] == '0);

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_idle |-> (!os_tick && !bit_tick));

    // R7
    bit_in_os_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);

    // R9
    sync_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_mode == 2'd1 || ser_mode == 2'd2) |-> (bit_tick == os_tick));

endmodule

bind frac_baud_gen fbg_chk #(
    .DATA_W(DATA_W), .FP_W(FP_W), .FP_LSB(FP_LSB)
) i_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .wprot_en(wprot_en),
    .cfg_rdata(cfg_rdata), .ser_mode(ser_mode), .os_tick(os_tick),
    .bit_tick(bit_tick), .core_idle(core_idle)
);

// File: tb/test_frac_baud_gen.sv
`timescale 1ns/1ps
module test_frac_baud_gen;

    logic        clk;
    logic        rst_n;
    logic        cfg_we;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        wprot_en;
    logic [1:0]  ser_mode;
    logic        over8;
    logic [10:0] card_ratio;
    logic        os_tick;
    logic        os_clk;
    logic        bit_tick;

    frac_baud_gen i_frac_baud_gen (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .wprot_en(wprot_en), .ser_mode(ser_mode),
        .over8(over8), .card_ratio(card_ratio), .os_tick(os_tick),
        .os_clk(os_clk), .bit_tick(bit_tick)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    typedef struct {
        int    len;
        int    high;
        string req;
    } os_item_t;

    os_item_t os_q[$];
    int       bit_q[$];
    string    bit_req;
    bit       os_armed  = 1'b0;
    bit       bit_armed = 1'b0;
    bit       done      = 1'b0;
    int       n_cmp     = 0;
    int       n_bad     = 0;
    int       cyc_n     = 0;
    int       last_os   = 0;
    int       last_bit  = 0;
    int       hi_cnt    = 0;
    os_item_t cur;
    int       exp_bit;

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: compares measured periods against queued expectations
    always @(negedge clk) begin
        cyc_n++;
        if (rst_n) begin
            if (os_clk) hi_cnt++;
            if (os_tick) begin
                if (os_armed && os_q.size() > 0) begin
                    cur = os_q.pop_front();
                    chk({cur.req, " period"}, cyc_n - last_os, cur.len);
                    chk({cur.req, " high"}, hi_cnt, cur.high);
                end
                last_os = cyc_n;
                hi_cnt  = 0;
            end
            if (bit_tick) begin
                if (bit_armed && bit_q.size() > 0) begin
                    exp_bit = bit_q.pop_front();
                    chk({bit_req, " bit period"}, cyc_n - last_bit, exp_bit);
                end
                last_bit = cyc_n;
            end
        end
    end

    task automatic wr(logic [31:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic wait_os(int n);
        repeat (n) begin
            @(negedge clk);
            while (!os_tick) @(negedge clk);
        end
    endtask

    task automatic wait_bit(int n);
        repeat (n) begin
            @(negedge clk);
            while (!bit_tick) @(negedge clk);
        end
    endtask

    task automatic push_os(int len, int high, string req);
        os_item_t it;
        it.len  = len;
        it.high = high;
        it.req  = req;
        os_q.push_back(it);
    endtask

    task automatic drain();
        while (os_q.size() != 0 || bit_q.size() != 0) @(negedge clk);
        os_armed  = 1'b0;
        bit_armed = 1'b0;
    endtask

    task automatic bit_case(logic [1:0] m, logic o8, int ratio, int per, string req);
        bit_armed  = 1'b0;
        ser_mode   = m;
        over8      = o8;
        card_ratio = 11'(ratio);
        wait_bit(2);
        @(negedge clk);
        bit_req   = req;
        bit_armed = 1'b1;
        bit_q.push_back(per);
        bit_q.push_back(per);
        drain();
    endtask

    task automatic os_case(int cd, int n, string req);
        os_armed = 1'b0;
        wr(32'(cd));
        wait_os(3);
        @(negedge clk);
        os_armed = 1'b1;
        repeat (n) push_os(cd, (cd + 1) / 2, req);
        drain();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int ticks;
        int k;
        rst_n      = 1'b0;
        cfg_we     = 1'b0;
        cfg_wdata  = '0;
        wprot_en   = 1'b0;
        ser_mode   = 2'd0;
        over8      = 1'b0;
        card_ratio = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 rdata", int'(cfg_rdata), 0);
        ticks = 0;
        repeat (30) begin
            @(negedge clk);
            if (os_tick || bit_tick) ticks++;
        end
        chk("R1 ticks", ticks, 0);

        // R2: field placement and zero bits
        wr(32'hFFFF_0003);
        @(negedge clk);
        chk("R2 readback", int'(cfg_rdata), 32'h0007_0003);

        // R3: protected write dropped
        wprot_en = 1'b1;
        wr(32'h0000_0009);
        @(negedge clk);
        chk("R3 readback", int'(cfg_rdata), 32'h0007_0003);
        wprot_en = 1'b0;

        // R5: integer periods, odd and even divisors
        os_case(5, 4, "R5");
        os_case(6, 3, "R5");
        os_case(5, 2, "R5");

        // R7..R10: final division per mode, CD = 5
        bit_case(2'd0, 1'b0, 0, 80, "R7");
        bit_case(2'd0, 1'b1, 0, 40, "R8");
        bit_case(2'd1, 1'b0, 0, 5,  "R9");
        bit_case(2'd2, 1'b0, 0, 5,  "R9");
        bit_case(2'd3, 1'b0, 3, 15, "R10");
        bit_case(2'd3, 1'b0, 0, 5,  "R10");

        // R4: divisor zero silences both ticks
        ser_mode = 2'd0;
        wr(32'h0);
        repeat (10) @(negedge clk);
        ticks = 0;
        repeat (50) begin
            @(negedge clk);
            if (os_tick || bit_tick) ticks++;
        end
        chk("R4 ticks", ticks, 0);

        // R11: clean restart from idle
        wr(32'd3);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!os_tick && k < 20);
        chk("R11 first tick", k, 3);

        // R4: bit stage cleared by idle, first bit after 16 periods of 3
        wr(32'h0);
        repeat (10) @(negedge clk);
        wr(32'd3);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!bit_tick && k < 200);
        chk("R4 bit count cleared", k, 48);

        // R6: CD=4 FP=3 from idle -> extended periods 3,6,8 of each 8
        wr(32'h0);
        repeat (10) @(negedge clk);
        wr(32'h0003_0004);
        wait_os(1);
        @(negedge clk);
        os_armed = 1'b1;
        push_os(4, 2, "R6"); push_os(5, 3, "R6"); push_os(4, 2, "R6");
        push_os(4, 2, "R6"); push_os(5, 3, "R6"); push_os(4, 2, "R6");
        push_os(5, 3, "R6"); push_os(4, 2, "R6");
        drain();

        // R6: CD=6 FP=1 from idle -> only the 8th period extended
        wr(32'h0);
        repeat (12) @(negedge clk);
        wr(32'h0001_0006);
        wait_os(1);
        @(negedge clk);
        os_armed = 1'b1;
        repeat (6) push_os(6, 3, "R6");
        push_os(7, 4, "R6");
        push_os(6, 3, "R6");
        drain();

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule